// File: doc/BRIEF.md
# Soft-Start Reference Ramp

This block produces the 5-bit reference level that sets the regulated feedback voltage of an LED boost driver. When the driver is enabled, the level starts at code 0 and climbs one code at a time, each code held for a fixed number of microsecond ticks (341 by default). It stops when it reaches the target level. While it climbs, a flag tells the switch current-limit circuit to use half of its normal limit. When the ramp completes, a done flag rises and the half-limit flag drops.

The target comes from one of two sources. If a level has been programmed, it is that level. If not, it is full scale, code 31. A combinational lookup turns the current code into a feedback voltage in millivolts on a pseudo-logarithmic scale.

During the ramp, the code climbs one step at a time. After the ramp ends, the code follows target changes at once. Dropping enable returns the block to code 0, and the next enable starts a fresh ramp.

Top module: `ss_ramp_top`

## Requirements
- R1: Out of synchronous active-low reset, `lvl_code` is 0 and both `ramp_active` and `ramp_done` are low.
- R2: A cycle in which `enable` is sampled low sets, at the next edge, `lvl_code` to 0 and clears `ramp_active` and `ramp_done`.
- R3: On the first edge that samples `enable` high from the idle state, `ramp_active` rises and `lvl_code` is 0.
- R4: During the ramp, `lvl_code` rises by exactly one after every `STEP_US` cycles that carry `tick_us` high. Cycles with `tick_us` low do not advance it.
- R5: One edge after `lvl_code` equals the target, `ramp_done` rises and `ramp_active` falls.
- R6: With `tgt_set` low, the target is full scale, code 31, whatever `tgt_code` holds.
- R7: If the target falls below `lvl_code` during the ramp, `lvl_code` takes the target value at the next edge and the ramp ends. The code never passes the target.
- R8: Once `ramp_done` is high, a change of target appears on `lvl_code` at the next edge, with no ramp.
- R9: `ref_mv` follows `lvl_code` combinationally, in millivolts:
  - code 0 gives 0;
  - codes 1..12 give 3*code+2;
  - codes 13..23 give 38+6*(code-12);
  - codes 24..31 give 104+12*(code-23), which is 200 at code 31.
- R10: `ramp_active` and `ramp_done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Driver enable, synchronous to clk |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| tgt_set | input | 1 | High when a level has been programmed |
| tgt_code | input | 5 | Programmed target level |
| lvl_code | output | 5 | Current reference level |
| ref_mv | output | 8 | Feedback voltage for `lvl_code`, in mV |
| ramp_active | output | 1 | Ramp running; current limit at half |
| ramp_done | output | 1 | Ramp complete; level tracks target |

## Verification
The fault that matters most is a wrong step interval in the tick counter. It shows up on `lvl_code` at its first code change, within one step of enable. The bench therefore measures every interval of a full 31-step ramp in cycles.

Three other faults show within one cycle of their cause:
- a state register stuck in the ramp state keeps `ramp_done` low past the final code;
- a missed clamp lets `lvl_code` sit above a lowered target;
- a bad level lookup mismatches `ref_mv` for the code shown.

The table is walked through all 32 codes in tracking mode so that each entry is observed.

// File: rtl/ss_ramp_pkg.sv
// Package: shared types and the level-to-millivolt law for the soft-start ramp.
// Assumes a 5-bit level code. The law is computed, not tabulated.
package ss_ramp_pkg;

    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RAMP = 2'd1,
        SS_HOLD = 2'd2
    } ss_state_t;

    // Pseudo-log map from level code to feedback millivolts.
    function automatic logic [7:0] level_to_mv(input logic [4:0] code);
        int c;
        int mv;
        c = int'(code);
        if (c == 0)
            mv = 0;
        else if (c <= 12)
            mv = 3 * c + 2;
        else if (c <= 23)
            mv = 38 + 6 * (c - 12);
        else
            mv = 104 + 12 * (c - 23);
        return mv[7:0];
    endfunction

endpackage

// File: rtl/ss_target_sel.sv
// Target selector: passes the programmed level when one is set,
// otherwise full scale. Purely combinational.
module ss_target_sel #(
    parameter int CODE_W = 5
) (
    input  logic              tgt_set,
    input  logic [CODE_W-1:0] tgt_code,
    output logic [CODE_W-1:0] eff_tgt
);
    localparam logic [CODE_W-1:0] FULL_SCALE = {CODE_W{1'b1}};

    // Choose the programmed or default target.
    always_comb begin
        eff_tgt = tgt_set ? tgt_code : FULL_SCALE;
    end
endmodule

// File: rtl/ss_step_timer.sv
// Step timer: counts tick strobes while running.
// It pulses step_stb on the tick that completes STEP_US ticks.
// Assumes clr is held high whenever the ramp is not running.
module ss_step_timer #(
    parameter int STEP_US = 341
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic step_stb
);
    localparam int CNT_W = (STEP_US > 1) ? $clog2(STEP_US) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_US - 1);

    logic [CNT_W-1:0] cnt_q;

    // The strobe fires on the tick that closes the interval.
    always_comb begin
        step_stb = !clr && tick && (cnt_q == LAST);
    end

    // Advance the tick count and wrap at the interval end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R4
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);  // R4
endmodule

// File: rtl/ss_ramp_fsm.sv
// Ramp sequencer. In idle it holds code 0. On enable it climbs one code
// per step strobe up to the target, clamping if the target drops below
// the code. In hold it tracks the target directly.
// Assumes enable is synchronous to clk.
module ss_ramp_fsm #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              step_stb,
    input  logic [CODE_W-1:0] eff_tgt,
    output logic [CODE_W-1:0] code,
    output logic              in_ramp,
    output logic              in_hold
);
    import ss_ramp_pkg::*;

    ss_state_t         st_q, st_d;
    logic [CODE_W-1:0] code_q, code_d;

    // Next-state and next-code decision.
    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        if (!enable) begin
            st_d   = SS_IDLE;
            code_d = '0;
        end else begin
            unique case (st_q)
                SS_IDLE: begin
                    st_d   = SS_RAMP;
                    code_d = '0;
                end
                SS_RAMP: begin
                    if (eff_tgt <= code_q) begin
                        st_d   = SS_HOLD;
                        code_d = eff_tgt;
                    end else if (step_stb) begin
                        code_d = code_q + 1'b1;
                    end
                end
                SS_HOLD: code_d = eff_tgt;
                default: begin
                    st_d   = SS_IDLE;
                    code_d = '0;
                end
            endcase
        end
    end

    // State and code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SS_IDLE;
            code_q <= '0;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    assign code    = code_q;
    assign in_ramp = (st_q == SS_RAMP);
    assign in_hold = (st_q == SS_HOLD);

    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (code_q == '0) && !in_ramp && !in_hold);  // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ramp && enable && eff_tgt > code_q && !step_stb) |=> $stable(code_q));  // R4
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ramp && enable && eff_tgt > code_q && step_stb) |=> code_q == $past(code_q) + 1'b1);  // R4
    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ramp && enable && eff_tgt <= code_q) |=> in_hold && code_q == $past(eff_tgt));  // R7
    AST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && enable) |=> code_q == $past(eff_tgt));  // R8
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ramp && in_hold));  // R10
endmodule

// File: rtl/ss_level_rom.sv
// Level lookup: maps the current code to feedback millivolts through the
// computed pseudo-log law in the package. Combinational.
module ss_level_rom #(
    parameter int CODE_W = 5,
    parameter int MV_W   = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic [MV_W-1:0]   mv
);
    import ss_ramp_pkg::*;

    // Evaluate the law for the presented code.
    always_comb begin
        mv = MV_W'(level_to_mv(5'(code)));
    end

    always_comb begin
        if (code == '0)
            AST_ZERO_MV: assert (mv == '0);  // R9
    end
endmodule

// File: rtl/ss_ramp_top.sv
// Soft-start reference ramp top. It ties the target selector, step timer,
// sequencer and level lookup together. ramp_active drives the halved
// current limit.
// Assumes tick_us is a one-cycle strobe, synchronous to clk.
module ss_ramp_top #(
    parameter int CODE_W  = 5,
    parameter int MV_W    = 8,
    parameter int STEP_US = 341
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick_us,
    input  logic              tgt_set,
    input  logic [CODE_W-1:0] tgt_code,
    output logic [CODE_W-1:0] lvl_code,
    output logic [MV_W-1:0]   ref_mv,
    output logic              ramp_active,
    output logic              ramp_done
);
    logic [CODE_W-1:0] eff_tgt;
    logic              step_stb;
    logic              in_ramp;
    logic              in_hold;

    ss_target_sel #(.CODE_W(CODE_W)) u_sel (
        .tgt_set (tgt_set),
        .tgt_code(tgt_code),
        .eff_tgt (eff_tgt)
    );

    ss_step_timer #(.STEP_US(STEP_US)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_ramp),
        .tick    (tick_us),
        .step_stb(step_stb)
    );

    ss_ramp_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .step_stb(step_stb),
        .eff_tgt (eff_tgt),
        .code    (lvl_code),
        .in_ramp (in_ramp),
        .in_hold (in_hold)
    );

    ss_level_rom #(.CODE_W(CODE_W), .MV_W(MV_W)) u_rom (
        .code(lvl_code),
        .mv  (ref_mv)
    );

    assign ramp_active = in_ramp;
    assign ramp_done   = in_hold;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_active && ramp_done));  // R10
    AST_DONE_AT_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_active && enable && lvl_code == eff_tgt) |=> ramp_done && !ramp_active);  // R5
endmodule

// File: tb/tb_ss_ramp_top.sv
// Directed bench for ss_ramp_top: one task per scenario.
// Inputs are driven and outputs sampled at the falling edge.
module tb_ss_ramp_top;
    localparam int STEP = 341;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       tick_us = 1'b1;
    logic       tgt_set = 1'b0;
    logic [4:0] tgt_code = 5'd0;
    logic [4:0] lvl_code;
    logic [7:0] ref_mv;
    logic       ramp_active;
    logic       ramp_done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ss_ramp_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick_us    (tick_us),
        .tgt_set    (tgt_set),
        .tgt_code   (tgt_code),
        .lvl_code   (lvl_code),
        .ref_mv     (ref_mv),
        .ramp_active(ramp_active),
        .ramp_done  (ramp_done)
    );

    function automatic int exp_mv(input int c);
        if (c == 0)
            return 0;
        if (c <= 12)
            return 3 * c + 2;
        if (c <= 23)
            return 38 + 6 * (c - 12);
        return 104 + 12 * (c - 23);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++)
            @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        enable = 1'b0;
        cyc(3);
        chk("R1 code", lvl_code, 0);
        chk("R1 active", ramp_active, 0);
        chk("R1 done", ramp_done, 0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // Full ramp to the default target, timing every step.
    task automatic t_full_ramp();
        int last;
        int prev;
        int bad_iv;
        int bad_act;
        int done_cyc;
        tgt_set = 1'b0;
        tgt_code = 5'd3;  // ignored while tgt_set is low (R6)
        tick_us = 1'b1;
        enable = 1'b1;
        cyc(1);
        chk("R3 active on enable", ramp_active, 1);
        chk("R3 code starts 0", lvl_code, 0);
        last = 1;
        prev = 0;
        bad_iv = 0;
        bad_act = 0;
        done_cyc = 0;
        for (int c = 2; c < 40 * STEP; c++) begin
            @(negedge clk);
            if (ramp_done) begin
                done_cyc = c;
                break;
            end
            if (!ramp_active)
                bad_act++;
            if (lvl_code != prev) begin
                if (c - last != STEP || lvl_code != prev + 1)
                    bad_iv++;
                last = c;
                prev = lvl_code;
            end
        end
        chk("R4 step interval errors", bad_iv, 0);
        chk("R5 active held through ramp", bad_act, 0);
        chk("R6 final code full scale", lvl_code, 31);
        chk("R5 done cycle", done_cyc, 2 + STEP * 31);
        chk("R10 active low at done", ramp_active, 0);
        chk("R9 ref at 31", ref_mv, 200);
    endtask

    task automatic t_disable();
        enable = 1'b0;
        cyc(1);
        chk("R2 code cleared", lvl_code, 0);
        chk("R2 done cleared", ramp_done, 0);
        chk("R2 active cleared", ramp_active, 0);
    endtask

    // Without ticks the code holds; with ticks it resumes.
    task automatic t_tick_gap();
        tgt_set = 1'b1;
        tgt_code = 5'd2;
        tick_us = 1'b0;
        enable = 1'b1;
        cyc(STEP * 3);
        chk("R4 no tick no advance", lvl_code, 0);
        chk("R4 still active", ramp_active, 1);
        tick_us = 1'b1;
        cyc(STEP);
        chk("R4 one step after ticks", lvl_code, 1);
        cyc(STEP);
        chk("R4 second step", lvl_code, 2);
        cyc(1);
        chk("R5 done at target", ramp_done, 1);
        enable = 1'b0;
        cyc(1);
    endtask

    // Lowering the target mid-ramp clamps without overshoot.
    task automatic t_clamp();
        tgt_set = 1'b1;
        tgt_code = 5'd20;
        enable = 1'b1;
        cyc(1 + STEP * 5);
        chk("R7 code before clamp", lvl_code, 5);
        tgt_code = 5'd3;
        cyc(1);
        chk("R7 clamped code", lvl_code, 3);
        chk("R7 ramp ended", ramp_done, 1);
    endtask

    // Tracking after done, walking the full table.
    task automatic t_track();
        int bad;
        bad = 0;
        for (int c = 0; c < 32; c++) begin
            tgt_code = 5'(c);
            cyc(1);
            if (lvl_code != c || ref_mv != exp_mv(c) || !ramp_done)
                bad++;
        end
        chk("R8 R9 tracking table mismatches", bad, 0);
        tgt_code = 5'd12;
        cyc(1);
        chk("R9 ref at 12", ref_mv, 38);
        chk("R8 immediate", lvl_code, 12);
        tgt_set = 1'b0;
        cyc(1);
        chk("R6 default in hold", lvl_code, 31);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_full_ramp();
                t_disable();
                t_tick_gap();
                t_clamp();
                t_track();
                t_disable();
            end
            begin
                cyc(150000);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule